// File: doc/BRIEF.md
# Single-Register Load/Store Access Unit

This unit carries out one single-register memory transfer for a 32-bit core. A decoded operation arrives in one cycle. It carries the base register value, an unsigned immediate, an add/subtract selector, pre-index and writeback selectors, a log2 transfer size, an access code, an endianness selector and two register indices: the data register and the base register. The unit works out the effective address and raises one memory request, holding it until the memory grants it. On a load, it waits for the returned data and formats it.

Results go back through a single register-file write port. The base-register update is written first, when writeback is requested. The data register writes follow it. A doubleword transfer uses the data register and its odd partner (index with bit 0 forced to 1), and the endianness selector decides which of them holds which half of the 64-bit value. Stores read their source registers through two combinational read ports while the operation is being accepted.

Top module: `ldst_unit`

## Requirements
- R1: The size field is log2 of the byte count: 0 byte, 1 halfword, 2 word, 3 doubleword. It is passed to `mem_size` unchanged. Bit 1 of the access code selects a load (1) or a store (0), and bit 0 selects sign extension, so 0 is a store, 2 is a zero-extending load and 3 is a sign-extending load. `mem_we` is high exactly for stores.
- R2: The offset address is the base plus the zero-extended immediate when `op_add` is 1. It is the base minus that immediate when `op_add` is 0. The arithmetic wraps modulo 2^32.
- R3: With `op_pre` set, `mem_addr` is the offset address. With it clear, `mem_addr` is the unmodified base.
- R4: When `op_wb` is set, the unit writes the offset address to register `op_rn`. This write comes before any data-register write of the same operation. When `op_wb` is clear, no write goes to the base register.
- R5: Byte and halfword loads take the low bits of `mem_rdata`. They are sign-extended to 32 bits for access code 3 and zero-extended for code 2. A word load writes `mem_rdata[31:0]` unchanged.
- R6: A doubleword load in little-endian mode (`op_big` = 0) writes `mem_rdata[31:0]` to Rt and `mem_rdata[63:32]` to Rt|1. In big-endian mode the two halves are swapped.
- R7: A doubleword store in little-endian mode drives `mem_wdata` = {R[Rt|1], R[Rt]}. In big-endian mode it drives {R[Rt], R[Rt|1]}. Narrower stores drive R[Rt], cut to the transfer size and zero-filled above it.
- R8: Once `mem_req` rises, it stays high until a cycle with `mem_gnt` high. Address, write enable, size and write data do not change while it waits.
- R9: A load writes no data register until `mem_rvalid` has been seen in some cycle after the grant.
- R10: A doubleword load writes Rt and Rt|1 in two consecutive cycles. `busy` is high from the cycle after acceptance through the last register write, and low in the next cycle. `op_ready` is the inverse of `busy`, and `op_valid` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit idle, operation accepted |
| op_base | input | 32 | Base register value |
| op_imm | input | 12 | Unsigned immediate offset |
| op_add | input | 1 | 1 add immediate, 0 subtract |
| op_pre | input | 1 | Access at the offset address |
| op_wb | input | 1 | Write offset address to base register |
| op_size | input | 2 | log2 transfer bytes |
| op_acc | input | 2 | Access code (0 store, 2 load, 3 signed load) |
| op_big | input | 1 | Big-endian doubleword word order |
| op_rt | input | 4 | Data register index |
| op_rn | input | 4 | Base register index |
| rf_raddr0 | output | 4 | Read port 0 index (Rt) |
| rf_rdata0 | input | 32 | Read port 0 data |
| rf_raddr1 | output | 4 | Read port 1 index (Rt\|1) |
| rf_rdata1 | input | 32 | Read port 1 data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_size | output | 2 | log2 transfer bytes |
| mem_wdata | output | 64 | Write data, right-aligned |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, right-aligned |
| busy | output | 1 | Operation in progress |

## Verification
The assertions rely on the memory side behaving in three ways. It grants only while a request is up. It returns exactly one read response per load, no earlier than the cycle after the grant. It sends nothing for stores. The register file is also assumed to stay stable while an operation is being accepted. The bench's memory model meets these conditions by construction: it raises `mem_gnt` only in a cycle where it sees `mem_req`, after a random delay. It sends one `mem_rvalid` pulse a random number of cycles after that grant, and only for loads. The bench changes its register contents only between operations. Stray `op_valid` pulses are sent only while `busy` is high.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } xfer_size_e;

  localparam int ACC_SIGNED_BIT = 0;
  localparam int ACC_LOAD_BIT   = 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_WAIT = 3'd2,
    S_WB   = 3'd3,
    S_WR0  = 3'd4,
    S_WR1  = 3'd5
  } lsu_state_e;
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic             add,
  input  logic             pre,
  output logic [XLEN-1:0]  ofs_addr,
  output logic [XLEN-1:0]  acc_addr
);
  function automatic logic [XLEN-1:0] f_offset(input logic [XLEN-1:0] b,
                                               input logic [IMM_W-1:0] i,
                                               input logic up);
    logic [XLEN-1:0] ext;
    ext = XLEN'(i);
    return up ? (b + ext) : (b - ext);
  endfunction

  assign ofs_addr = f_offset(base, imm, add);
  assign acc_addr = pre ? ofs_addr : base;
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
  import ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2*XLEN-1:0] rdata,
  input  logic [1:0]        size,
  input  logic              sgn,
  input  logic              big,
  output logic [XLEN-1:0]   word_rt,
  output logic [XLEN-1:0]   word_rt1
);
  logic [XLEN-1:0] lo_w, hi_w;
  assign lo_w = rdata[XLEN-1:0];
  assign hi_w = rdata[2*XLEN-1:XLEN];

  function automatic logic [XLEN-1:0] f_extend(input logic [XLEN-1:0] w,
                                               input logic [1:0] sz,
                                               input logic s);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_BYTE: r = s ? {{(XLEN-8){w[7]}}, w[7:0]}   : {{(XLEN-8){1'b0}}, w[7:0]};
      SZ_HALF: r = s ? {{(XLEN-16){w[15]}}, w[15:0]} : {{(XLEN-16){1'b0}}, w[15:0]};
      default: r = w;
    endcase
    return r;
  endfunction

  always_comb begin
    if (size == SZ_DBL) begin
      word_rt  = big ? hi_w : lo_w;
      word_rt1 = big ? lo_w : hi_w;
    end else begin
      word_rt  = f_extend(lo_w, size, sgn);
      word_rt1 = hi_w;
    end
  end

  // R5: a signed byte result carries the byte's top bit through the upper bits
  always_comb begin
    if (size == SZ_BYTE && sgn)
      p_sext_byte_r5: assert (word_rt[XLEN-1:8] == {(XLEN-8){rdata[7]}});
  end
endmodule

// File: rtl/ldst_store_pack.sv
module ldst_store_pack
  import ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   d_rt,
  input  logic [XLEN-1:0]   d_rt1,
  input  logic [1:0]        size,
  input  logic              big,
  output logic [2*XLEN-1:0] wdata
);
  function automatic logic [XLEN-1:0] f_trim(input logic [XLEN-1:0] w,
                                             input logic [1:0] sz);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_BYTE: r = {{(XLEN-8){1'b0}}, w[7:0]};
      SZ_HALF: r = {{(XLEN-16){1'b0}}, w[15:0]};
      default: r = w;
    endcase
    return r;
  endfunction

  always_comb begin
    if (size == SZ_DBL)
      wdata = big ? {d_rt, d_rt1} : {d_rt1, d_rt};
    else
      wdata = {{XLEN{1'b0}}, f_trim(d_rt, size)};
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int RIDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [XLEN-1:0]     op_base,
  input  logic [IMM_W-1:0]    op_imm,
  input  logic                op_add,
  input  logic                op_pre,
  input  logic                op_wb,
  input  logic [1:0]          op_size,
  input  logic [1:0]          op_acc,
  input  logic                op_big,
  input  logic [RIDX_W-1:0]   op_rt,
  input  logic [RIDX_W-1:0]   op_rn,
  output logic [RIDX_W-1:0]   rf_raddr0,
  input  logic [XLEN-1:0]     rf_rdata0,
  output logic [RIDX_W-1:0]   rf_raddr1,
  input  logic [XLEN-1:0]     rf_rdata1,
  output logic                rf_we,
  output logic [RIDX_W-1:0]   rf_waddr,
  output logic [XLEN-1:0]     rf_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [XLEN-1:0]     mem_addr,
  output logic [1:0]          mem_size,
  output logic [2*XLEN-1:0]   mem_wdata,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [2*XLEN-1:0]   mem_rdata,
  output logic                busy
);
  localparam int DW = 2 * XLEN;
  localparam logic [RIDX_W-1:0] PAIR_BIT = RIDX_W'(1);

  lsu_state_e state_q, state_d;

  logic [XLEN-1:0]   addr_q, ofs_q, ld_rt_q, ld_rt1_q;
  logic [DW-1:0]     wdata_q;
  logic              store_q, sgn_q, big_q, wb_q;
  logic [1:0]        size_q;
  logic [RIDX_W-1:0] rt_q, rn_q;

  logic [XLEN-1:0]   ofs_addr, acc_addr, fmt_rt, fmt_rt1;
  logic [DW-1:0]     st_data;

  // Operand read ports follow the incoming operation
  assign rf_raddr0 = op_rt;
  assign rf_raddr1 = op_rt | PAIR_BIT;

  ldst_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .base(op_base), .imm(op_imm), .add(op_add), .pre(op_pre),
    .ofs_addr(ofs_addr), .acc_addr(acc_addr)
  );

  ldst_store_pack #(.XLEN(XLEN)) u_pack (
    .d_rt(rf_rdata0), .d_rt1(rf_rdata1), .size(op_size), .big(op_big),
    .wdata(st_data)
  );

  ldst_load_fmt #(.XLEN(XLEN)) u_fmt (
    .rdata(mem_rdata), .size(size_q), .sgn(sgn_q), .big(big_q),
    .word_rt(fmt_rt), .word_rt1(fmt_rt1)
  );

  // Named events for the assertions
  logic ev_accept, ev_grant, ev_resp, ev_first_dbl, ev_final_wr;
  assign busy         = (state_q != S_IDLE);
  assign op_ready     = !busy;
  assign ev_accept    = op_valid && op_ready;
  assign ev_grant     = (state_q == S_REQ) && mem_gnt;
  assign ev_resp      = (state_q == S_WAIT) && mem_rvalid;
  assign ev_first_dbl = (state_q == S_WR0) && (size_q == SZ_DBL);
  assign ev_final_wr  = (state_q == S_WR1) ||
                        ((state_q == S_WR0) && (size_q != SZ_DBL)) ||
                        ((state_q == S_WB) && store_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (op_valid) state_d = S_REQ;
      S_REQ:  if (mem_gnt) state_d = store_q ? (wb_q ? S_WB : S_IDLE) : S_WAIT;
      S_WAIT: if (mem_rvalid) state_d = wb_q ? S_WB : S_WR0;
      S_WB:   state_d = store_q ? S_IDLE : S_WR0;
      S_WR0:  state_d = (size_q == SZ_DBL) ? S_WR1 : S_IDLE;
      S_WR1:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      ofs_q    <= '0;
      wdata_q  <= '0;
      store_q  <= 1'b0;
      sgn_q    <= 1'b0;
      big_q    <= 1'b0;
      wb_q     <= 1'b0;
      size_q   <= '0;
      rt_q     <= '0;
      rn_q     <= '0;
      ld_rt_q  <= '0;
      ld_rt1_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        addr_q  <= acc_addr;
        ofs_q   <= ofs_addr;
        store_q <= !op_acc[ACC_LOAD_BIT];
        sgn_q   <= op_acc[ACC_SIGNED_BIT];
        big_q   <= op_big;
        wb_q    <= op_wb;
        size_q  <= op_size;
        rt_q    <= op_rt;
        rn_q    <= op_rn;
        wdata_q <= op_acc[ACC_LOAD_BIT] ? '0 : st_data;
      end
      if (ev_resp) begin
        ld_rt_q  <= fmt_rt;
        ld_rt1_q <= fmt_rt1;
      end
    end
  end

  assign mem_req   = (state_q == S_REQ);
  assign mem_we    = store_q;
  assign mem_addr  = addr_q;
  assign mem_size  = size_q;
  assign mem_wdata = wdata_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rt_q;
    rf_wdata = ld_rt_q;
    case (state_q)
      S_WB:  begin rf_we = 1'b1; rf_waddr = rn_q;            rf_wdata = ofs_q;    end
      S_WR0: begin rf_we = 1'b1; rf_waddr = rt_q;            rf_wdata = ld_rt_q;  end
      S_WR1: begin rf_we = 1'b1; rf_waddr = rt_q | PAIR_BIT; rf_wdata = ld_rt1_q; end
      default: ;
    endcase
  end

  // R8: a waiting request keeps every attribute
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            $stable(mem_size) && $stable(mem_wdata));

  // R9: no register write in the cycle after a load is granted
  p_no_early_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant && !mem_we |=> !rf_we);

  // R10: the odd partner write follows the first doubleword write
  p_dbl_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first_dbl |=> rf_we && (rf_waddr == ($past(rf_waddr) | PAIR_BIT)));

  // R10: busy drops right after the final write
  p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final_wr |=> !busy);

  // R10: acceptance starts a request
  p_accept_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy && mem_req);

  // R4: register writes and memory requests never overlap
  p_wr_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req && busy);
endmodule

// File: tb/ldst_unit_test.sv
module ldst_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        op_valid = 0, op_ready;
  logic [31:0] op_base = 0;
  logic [11:0] op_imm = 0;
  logic        op_add = 0, op_pre = 0, op_wb = 0, op_big = 0;
  logic [1:0]  op_size = 0, op_acc = 0;
  logic [3:0]  op_rt = 0, op_rn = 0;
  logic [3:0]  rf_raddr0, rf_raddr1, rf_waddr;
  logic [31:0] rf_rdata0, rf_rdata1, rf_wdata;
  logic        rf_we, mem_req, mem_we, busy;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata;
  logic        mem_gnt = 0, mem_rvalid = 0;
  logic [63:0] mem_rdata = 0;

  logic [31:0] bank [16];
  assign rf_rdata0 = bank[rf_raddr0];
  assign rf_rdata1 = bank[rf_raddr1];

  int total = 0, bad = 0;

  ldst_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_base(op_base), .op_imm(op_imm), .op_add(op_add), .op_pre(op_pre),
    .op_wb(op_wb), .op_size(op_size), .op_acc(op_acc), .op_big(op_big),
    .op_rt(op_rt), .op_rn(op_rn), .rf_raddr0(rf_raddr0), .rf_rdata0(rf_rdata0),
    .rf_raddr1(rf_raddr1), .rf_rdata1(rf_rdata1), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] x_offset(input logic [31:0] b, input logic [11:0] i,
                                           input logic up);
    logic [31:0] e = {20'd0, i};
    return up ? b + e : b - e;
  endfunction

  function automatic logic [31:0] x_ext(input logic [63:0] d, input logic [1:0] sz,
                                        input logic s);
    if (sz == 2'd0) return s ? {{24{d[7]}}, d[7:0]} : {24'd0, d[7:0]};
    if (sz == 2'd1) return s ? {{16{d[15]}}, d[15:0]} : {16'd0, d[15:0]};
    return d[31:0];
  endfunction

  function automatic logic [63:0] x_store(input logic [3:0] rt, input logic [1:0] sz,
                                          input logic be);
    logic [31:0] a = bank[rt];
    logic [31:0] b = bank[rt | 4'd1];
    case (sz)
      2'd0: return {56'd0, a[7:0]};
      2'd1: return {48'd0, a[15:0]};
      2'd2: return {32'd0, a};
      default: return be ? {a, b} : {b, a};
    endcase
  endfunction

  task automatic run_op(input logic [31:0] base, input logic [11:0] imm,
                        input logic add, input logic pre, input logic wb,
                        input logic [1:0] sz, input logic [1:0] acc, input logic be,
                        input logic [3:0] rt, input logic [3:0] rn,
                        input int gdly, input int rdly, input logic [63:0] rd,
                        input bit inject);
    logic [3:0]  wa [4];
    logic [31:0] wd [4];
    int          wc [4];
    logic [3:0]  ea [4];
    logic [31:0] ed [4];
    int nw = 0, ne = 0, req_c = -1, gnt_c = -1, rv_c = -1, done_c = -1;
    bit seen = 0, granted = 0, sent = 0, stable_ok = 1;
    logic [31:0] c_addr = 0;
    logic c_we = 0;
    logic [1:0] c_sz = 0;
    logic [63:0] c_wd = 0;
    logic is_load = acc[1];
    logic [31:0] ofs = x_offset(base, imm, add);
    for (int k = 0; k < 16; k++) bank[k] = $urandom;
    @(negedge clk);
    chk(op_ready == 1'b1 && busy == 1'b0, "R10 ready when idle", {63'd0, op_ready}, 64'd1);
    op_valid = 1; op_base = base; op_imm = imm; op_add = add; op_pre = pre;
    op_wb = wb; op_size = sz; op_acc = acc; op_big = be; op_rt = rt; op_rn = rn;
    @(negedge clk);
    for (int c = 0; c < 80; c++) begin
      op_valid = 0; mem_gnt = 0; mem_rvalid = 0;
      if (!busy) begin done_c = c; break; end
      if (rf_we && nw < 4) begin wa[nw] = rf_waddr; wd[nw] = rf_wdata; wc[nw] = c; nw++; end
      if (mem_req) begin
        if (!seen) begin
          seen = 1; req_c = c; c_addr = mem_addr; c_we = mem_we; c_sz = mem_size; c_wd = mem_wdata;
        end else if (mem_addr != c_addr || mem_we != c_we || mem_size != c_sz || mem_wdata != c_wd)
          stable_ok = 0;
        if (!granted && c - req_c >= gdly) begin mem_gnt = 1; granted = 1; gnt_c = c; end
      end
      if (granted && is_load && !sent && c >= gnt_c + 1 + rdly) begin
        mem_rvalid = 1; mem_rdata = rd; sent = 1; rv_c = c;
      end
      if (inject && c == 1) begin
        op_valid = 1; op_base = ~base; op_acc = 2'd0; op_rt = ~rt; op_rn = ~rn;
      end
      @(negedge clk);
    end
    op_valid = 0;
    // expected write list: base update first, then data registers
    if (wb) begin ea[ne] = rn; ed[ne] = ofs; ne++; end
    if (is_load) begin
      if (sz == 2'd3) begin
        ea[ne] = rt;        ed[ne] = be ? rd[63:32] : rd[31:0]; ne++;
        ea[ne] = rt | 4'd1; ed[ne] = be ? rd[31:0] : rd[63:32]; ne++;
      end else begin
        ea[ne] = rt; ed[ne] = x_ext(rd, sz, acc[0]); ne++;
      end
    end
    chk(seen, "R8 request raised", {63'd0, seen}, 64'd1);
    chk(c_addr == (pre ? ofs : base), "R2/R3 address", {32'd0, c_addr}, {32'd0, pre ? ofs : base});
    chk(c_we == !is_load, "R1 write enable", {63'd0, c_we}, {63'd0, !is_load});
    chk(c_sz == sz, "R1 size", {62'd0, c_sz}, {62'd0, sz});
    if (!is_load) chk(c_wd == x_store(rt, sz, be), "R7 store data", c_wd, x_store(rt, sz, be));
    chk(stable_ok, "R8 held request stable", {63'd0, stable_ok}, 64'd1);
    chk(nw == ne, "R4 write count", nw, ne);
    for (int k = 0; k < ne && k < nw; k++) begin
      chk(wa[k] == ea[k], (wb && k == 0) ? "R4 write index" : "R6 write index",
          {60'd0, wa[k]}, {60'd0, ea[k]});
      chk(wd[k] == ed[k], (wb && k == 0) ? "R4 base value" : (sz == 2'd3 ? "R6 dbl value" : "R5 load value"),
          {32'd0, wd[k]}, {32'd0, ed[k]});
    end
    if (is_load && nw > 0)
      chk(wc[0] > rv_c, "R9 write after response", wc[0], rv_c + 1);
    if (is_load && sz == 2'd3 && nw >= 2)
      chk(wc[nw-1] == wc[nw-2] + 1, "R10 consecutive pair", wc[nw-1], wc[nw-2] + 1);
    if (nw > 0) chk(done_c == wc[nw-1] + 1, "R10 busy until last write", done_c, wc[nw-1] + 1);
    if (inject) begin
      for (int k = 0; k < 3; k++) begin
        chk(!mem_req && !rf_we && !busy, "R10 ignored op while busy",
            {61'd0, mem_req, rf_we, busy}, 64'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int seed = 7;
    void'($urandom(seed));
    for (int k = 0; k < 16; k++) bank[k] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && op_ready && !mem_req && !rf_we, "R10 reset state",
        {60'd0, busy, op_ready, mem_req, rf_we}, 64'h4);
    rst_n = 1;
    // directed corners
    run_op(32'h0, 12'h1, 0, 1, 1, 2'd2, 2'd2, 0, 4'd2, 4'd3, 0, 0, 64'h1234_5678_9abc_def0, 0); // R2 wrap below zero
    run_op(32'hFFFF_FFF0, 12'h20, 1, 0, 1, 2'd2, 2'd0, 0, 4'd4, 4'd5, 3, 0, 64'h0, 0);          // R3 post-index, wrap up
    run_op(32'h100, 12'h4, 1, 1, 0, 2'd0, 2'd3, 0, 4'd1, 4'd6, 1, 2, 64'h0000_0000_0000_0080, 0); // R5 negative byte
    run_op(32'h100, 12'h4, 1, 1, 0, 2'd1, 2'd3, 0, 4'd1, 4'd6, 0, 0, 64'h0000_0000_0000_8001, 0); // R5 negative half
    run_op(32'h100, 12'h4, 1, 1, 0, 2'd1, 2'd2, 0, 4'd1, 4'd6, 0, 1, 64'h0000_0000_0000_8001, 0); // R5 zero-extend
    run_op(32'h200, 12'h8, 1, 1, 1, 2'd3, 2'd2, 0, 4'd8, 4'd7, 2, 1, 64'hAAAA_BBBB_CCCC_DDDD, 0); // R6 little
    run_op(32'h200, 12'h8, 1, 1, 1, 2'd3, 2'd2, 1, 4'd8, 4'd7, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD, 0); // R6 big
    run_op(32'h200, 12'h8, 1, 1, 0, 2'd3, 2'd2, 0, 4'd9, 4'd7, 0, 0, 64'h1111_2222_3333_4444, 0); // R6 odd Rt
    run_op(32'h300, 12'h0, 1, 1, 0, 2'd3, 2'd0, 0, 4'd10, 4'd7, 5, 0, 64'h0, 0);                 // R7 little
    run_op(32'h300, 12'h0, 1, 1, 0, 2'd3, 2'd0, 1, 4'd10, 4'd7, 0, 0, 64'h0, 0);                 // R7 big
    run_op(32'h300, 12'h3, 0, 1, 0, 2'd0, 2'd0, 0, 4'd11, 4'd7, 0, 0, 64'h0, 1);                 // R7 byte, R10 inject
    run_op(32'h400, 12'h10, 1, 0, 1, 2'd2, 2'd2, 0, 4'd5, 4'd5, 4, 6, 64'hDEAD_BEEF_0BAD_F00D, 1); // R4 Rn==Rt
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0] acc_r;
      int a = $urandom_range(0, 2);
      acc_r = (a == 0) ? 2'd0 : (a == 1) ? 2'd2 : 2'd3;
      run_op($urandom, 12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             2'($urandom), acc_r, 1'($urandom), 4'($urandom), 4'($urandom),
             $urandom_range(0, 4), $urandom_range(0, 4), {$urandom, $urandom},
             ($urandom_range(0, 7) == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule